// File: doc/BRIEF.md
# ISA Plug-and-Play Initiation Key Detector

This block watches byte writes to the Plug-and-Play address port. While the card waits for its initiation key, each written byte is compared against the next byte of a fixed 32-byte sequence. When all 32 bytes arrive in order, the block raises a single-cycle pulse, and the surrounding phase logic uses that pulse to move the card into its sleep phase. A wrong byte throws away any partial progress, so software has to start the key again from its first byte.

The expected bytes are not stored in a table. An 8-bit shift register produces them one after another, starting from the seed 0x6A. Each step shifts right by one place, and the new most significant bit is the XOR of the two least significant bits of the previous value. In every phase other than wait-for-key, the same address-port write loads an 8-bit register-index latch, and the other configuration logic decodes that latch.

Top module: `pnp_key_detector`

## Requirements
- R1: After synchronous reset, `keyFound` is 0, `addrReg` is 0x00, and the detector expects the first key byte.
- R2: In the wait-for-key phase (`waitForKey`=1), writing the 32 key bytes in order raises `keyFound` in the cycle after the 32nd write. The first byte is 0x6A. Each later byte is the previous one shifted right by one bit, with bit 7 set to bit 0 XOR bit 1 of the previous byte. The sequence runs 0x6A, 0xB5, 0xDA, 0xED, 0xF6, 0xFB, 0x7D, 0xBE, … and ends 0xE7, 0x73, 0x39.
- R3: In the wait-for-key phase, a write whose byte differs from the expected byte clears the progress to zero. The mismatching byte itself is never counted as a first byte, even when it equals 0x6A.
- R4: Any cycle with `waitForKey`=0 discards partial progress, so a key interrupted by a phase change must be restarted from 0x6A.
- R5: `keyFound` is high for exactly one cycle per completed key and never fires for a partial sequence. Idle cycles between key writes do not break the match.
- R6: While `waitForKey`=0, a write loads `wrData` into `addrReg`, and the new value is visible in the cycle after the write.
- R7: While `waitForKey`=1, writes leave `addrReg` unchanged.
- R8: After a completed key, matching restarts from the first byte, so a second full sequence gives a second pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrStrobe | input | 1 | One-cycle strobe for a byte write to the address port |
| wrData | input | 8 | Byte being written |
| waitForKey | input | 1 | High while the card is in the wait-for-key phase |
| keyFound | output | 1 | One-cycle pulse when the complete key has been seen |
| addrReg | output | 8 | Register-index latch, loaded outside the wait-for-key phase |

## Verification
The assertions assume that `wrStrobe` marks exactly one write per cycle. They also assume that `waitForKey` changes only on clock edges and that the surrounding logic drops it only after the pulse. The progress checks rely on `keyFound` never coinciding with a phase change. The stimulus drives every input on the falling edge and raises the strobe for one cycle per write. It changes the phase only between writes, which keeps all of these assumptions true, while still covering phase drops in the middle of a key, mismatches, and back-to-back keys.

// File: rtl/pnp_key_pkg.sv
package pnp_key_pkg;
  localparam int DATA_W = 8;

  // control-to-datapath strobes
  typedef struct packed {
    logic advance;   // step generator and counter
    logic restart;   // reload seed, clear counter
    logic loadAddr;  // capture written byte as register index
  } keyStrobes_t;

  // one step of the key generator: shift right, new MSB = b0 ^ b1
  function automatic logic [DATA_W-1:0] keyStep(input logic [DATA_W-1:0] cur);
    keyStep = {cur[0] ^ cur[1], cur[DATA_W-1:1]};
  endfunction
endpackage

// File: rtl/pnp_key_datapath.sv
module pnp_key_datapath
  import pnp_key_pkg::*;
#(
  parameter int KEY_LEN = 32,
  parameter logic [DATA_W-1:0] SEED = 8'h6A,
  localparam int CNT_W = $clog2(KEY_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  keyStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic              byteMatch,
  output logic [CNT_W-1:0]  keyCount,
  output logic [DATA_W-1:0] addrReg
);
  logic [DATA_W-1:0] expByte;

  assign byteMatch = (wrData == expByte);

  always_ff @(posedge clk) begin
    if (rst) begin
      expByte  <= SEED;
      keyCount <= '0;
    end else if (strobes.restart) begin
      expByte  <= SEED;
      keyCount <= '0;
    end else if (strobes.advance) begin
      expByte  <= keyStep(expByte);
      keyCount <= keyCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   addrReg <= '0;
    else if (strobes.loadAddr) addrReg <= wrData;
  end

  // counter and generator stay aligned: zero progress means seed expected
  p_seed_align_r3: assert property (@(posedge clk) disable iff (rst)
    (keyCount == '0) |-> (expByte == SEED));

  // index latch moves only on a load strobe
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadAddr |=> $stable(addrReg));
endmodule

// File: rtl/pnp_key_ctrl.sv
module pnp_key_ctrl
  import pnp_key_pkg::*;
#(
  parameter int KEY_LEN = 32,
  localparam int CNT_W = $clog2(KEY_LEN),
  localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_LEN - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrStrobe,
  input  logic             waitForKey,
  input  logic             byteMatch,
  input  logic [CNT_W-1:0] keyCount,
  output keyStrobes_t      strobes,
  output logic             keyFound
);
  logic keyWrite, lastByte, hit;

  assign keyWrite = wrStrobe & waitForKey;
  assign lastByte = (keyCount == LAST);
  assign hit      = keyWrite & byteMatch & lastByte;

  always_comb begin
    strobes          = '0;
    strobes.loadAddr = wrStrobe & ~waitForKey;
    strobes.advance  = keyWrite & byteMatch & ~lastByte;
    strobes.restart  = ~waitForKey | (keyWrite & (~byteMatch | lastByte));
  end

  always_ff @(posedge clk) begin
    if (rst) keyFound <= 1'b0;
    else     keyFound <= hit;
  end

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.advance, strobes.loadAddr}));

  p_mismatch_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (keyWrite && !byteMatch) |=> (keyCount == '0));

  p_phase_drop_r4: assert property (@(posedge clk) disable iff (rst)
    !waitForKey |=> (keyCount == '0));

  p_pulse_width_r5: assert property (@(posedge clk) disable iff (rst)
    keyFound |=> !keyFound);

  p_pulse_cause_r2: assert property (@(posedge clk) disable iff (rst)
    keyFound |-> ($past(keyCount) == LAST && $past(wrStrobe) && $past(waitForKey)));

  p_restart_after_r8: assert property (@(posedge clk) disable iff (rst)
    keyFound |-> (keyCount == '0));
endmodule

// File: rtl/pnp_key_detector.sv
module pnp_key_detector
  import pnp_key_pkg::*;
#(
  parameter int KEY_LEN = 32,
  parameter logic [7:0] SEED = 8'h6A
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrStrobe,
  input  logic [7:0] wrData,
  input  logic       waitForKey,
  output logic       keyFound,
  output logic [7:0] addrReg
);
  localparam int CNT_W = $clog2(KEY_LEN);

  keyStrobes_t      strobes;
  logic             byteMatch;
  logic [CNT_W-1:0] keyCount;

  pnp_key_ctrl #(.KEY_LEN(KEY_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .waitForKey(waitForKey),
    .byteMatch(byteMatch), .keyCount(keyCount),
    .strobes(strobes), .keyFound(keyFound)
  );

  pnp_key_datapath #(.KEY_LEN(KEY_LEN), .SEED(SEED)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .wrData(wrData),
    .byteMatch(byteMatch), .keyCount(keyCount), .addrReg(addrReg)
  );
endmodule

// File: tb/pnp_key_detector_tb.sv
module pnp_key_detector_tb;
  logic clk = 0, rst = 1, wrStrobe = 0, waitForKey = 0;
  logic [7:0] wrData = 0;
  logic keyFound;
  logic [7:0] addrReg;
  int tests = 0, fails = 0, pulses = 0;

  always #4 clk = ~clk; // 125 MHz

  pnp_key_detector u_dut (.clk(clk), .rst(rst), .wrStrobe(wrStrobe), .wrData(wrData),
    .waitForKey(waitForKey), .keyFound(keyFound), .addrReg(addrReg));

  localparam logic [7:0] KEY [32] = '{
    8'h6A, 8'hB5, 8'hDA, 8'hED, 8'hF6, 8'hFB, 8'h7D, 8'hBE,
    8'hDF, 8'h6F, 8'h37, 8'h1B, 8'h0D, 8'h86, 8'hC3, 8'h61,
    8'hB0, 8'h58, 8'h2C, 8'h16, 8'h8B, 8'h45, 8'hA2, 8'hD1,
    8'hE8, 8'h74, 8'h3A, 8'h9D, 8'hCE, 8'hE7, 8'h73, 8'h39};

  typedef struct packed { logic wfk; logic [7:0] d; logic [7:0] expAddr; } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b0, 8'h07, 8'h07}, '{1'b0, 8'hF5, 8'hF5}, '{1'b1, 8'h6A, 8'hF5},
    '{1'b1, 8'h00, 8'hF5}, '{1'b0, 8'h30, 8'h30}, '{1'b1, 8'hB5, 8'h30},
    '{1'b0, 8'hFF, 8'hFF}, '{1'b0, 8'h00, 8'h00}};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one write; returns keyFound seen in the cycle after it
  task automatic wr(input logic [7:0] d, output logic kf);
    wrStrobe = 1; wrData = d;
    @(negedge clk);
    wrStrobe = 0;
    kf = keyFound;
    if (kf) pulses++;
  endtask

  // sends key bytes [from..to]; returns count of pulses seen
  task automatic sendKey(input int from, input int to, input int gap, output int seen);
    logic kf;
    seen = 0;
    for (int i = from; i <= to; i++) begin
      wr(KEY[i], kf);
      if (kf) seen++;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (keyFound) seen++;
      end
    end
  endtask

  task automatic finish();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    int seen;
    logic kf;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 keyFound", {7'd0, keyFound}, 8'h00);
    check("R1 addrReg", addrReg, 8'h00);

    // R6/R7 vector table
    for (int i = 0; i < 8; i++) begin
      waitForKey = VECS[i].wfk;
      @(negedge clk);
      wr(VECS[i].d, kf);
      check(VECS[i].wfk ? "R7 addr hold" : "R6 addr load", addrReg, VECS[i].expAddr);
      check("R5 no pulse", {7'd0, kf}, 8'h00);
    end

    // R2 full key, R5 single pulse
    waitForKey = 0; @(negedge clk); waitForKey = 1; @(negedge clk);
    sendKey(0, 30, 0, seen);
    check("R5 partial", seen[7:0], 8'd0);
    wr(KEY[31], kf);
    check("R2 pulse", {7'd0, kf}, 8'h01);
    @(negedge clk);
    check("R5 one cycle", {7'd0, keyFound}, 8'h00);

    // R8 back-to-back second key, with idle gaps (R5)
    sendKey(0, 31, 2, seen);
    check("R8 second key", seen[7:0], 8'd1);

    // R3 mismatch mid-key then retry from start
    sendKey(0, 9, 0, seen);
    wr(8'h00, kf);
    sendKey(10, 31, 0, seen);
    check("R3 no resume", seen[7:0], 8'd0);
    sendKey(0, 31, 0, seen);
    check("R3 full after mismatch", seen[7:0], 8'd1);

    // R3 mismatch byte equal to seed is not a first byte
    sendKey(0, 1, 0, seen);
    wr(8'h6A, kf);
    sendKey(1, 31, 0, seen);
    check("R3 seed not counted", seen[7:0], 8'd0);

    // R4 phase drop mid-key
    sendKey(0, 15, 0, seen);
    waitForKey = 0; @(negedge clk); waitForKey = 1; @(negedge clk);
    sendKey(16, 31, 0, seen);
    check("R4 progress lost", seen[7:0], 8'd0);
    sendKey(0, 31, 0, seen);
    check("R4 restart works", seen[7:0], 8'd1);

    // key bytes outside wait phase do nothing but load addrReg
    waitForKey = 0; @(negedge clk);
    sendKey(0, 31, 0, seen);
    check("R6 no pulse outside", seen[7:0], 8'd0);
    check("R6 last load", addrReg, 8'h39);

    // R1 reset mid-key
    waitForKey = 1; @(negedge clk);
    sendKey(0, 20, 0, seen);
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    check("R1 addr after reset", addrReg, 8'h00);
    sendKey(21, 31, 0, seen);
    check("R1 progress cleared", seen[7:0], 8'd0);
    sendKey(0, 31, 0, seen);
    check("R1 key after reset", seen[7:0], 8'd1);
    finish();
  end
endmodule